// File: doc/BRIEF.md
# Bus Master Latency Timer

This block bounds the time the master that currently owns a shared bus may keep it while another master is waiting. Software programs a 16-bit hold limit through a plain register port that presents a 64-bit word. Each time the arbiter hands the bus to a new owner, it pulses a grant-start input. That pulse copies the hold limit into a down-counter. The counter then steps down by one on every bus clock and stops at zero.

Once the counter sits at zero, the block raises a release request to the current owner, but only while a peer request input shows that some other master is waiting. An owner with no competition therefore keeps the bus for as long as it likes. A new grant-start pulse reloads the counter, which withdraws the release request. A changed hold limit is picked up only at the next grant-start, so the tenure already running keeps the limit it started with.

Top module: `bus_hold_limiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `release_req` is 0 and `cfg_rdata` reads 0x0000_0000_0000_FFFF.
- R2: A cycle with `cfg_wr` high stores `cfg_wdata[15:0]` as the hold limit, and `cfg_rdata[15:0]` shows it from the next cycle. Bits 63:16 of `cfg_rdata` always read 0, whatever was written to them.
- R3: On a clock edge with `grant_start` high, the counter loads the hold limit that was stored before that edge.
- R4: With a limit L, a peer request held high and no further `grant_start`, `release_req` is 0 for the L cycles that follow the grant edge and becomes 1 after the L-th subsequent edge.
- R5: `release_req` is 1 only while `peer_req` is 1. An owner with no peer request never sees a release request, however long its tenure lasts.
- R6: The counter stops at zero and does not wrap. Within a tenure, `release_req` follows `peer_req` cycle by cycle once the count is zero.
- R7: A write to the hold limit does not alter the countdown in progress. A write on the same edge as `grant_start` loads the old limit, and the new limit applies from the following grant.
- R8: A hold limit of 0 makes `release_req` assert in the first cycle after the grant edge in which `peer_req` is high.
- R9: A `grant_start` pulse clears an asserted `release_req` from the next cycle, unless the reloaded limit is 0.
- R10: Before the first `grant_start` after reset, `release_req` stays 0 even with `peer_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 64 | Register write word; only bits 15:0 are kept |
| cfg_rdata | output | 64 | Register read word; hold limit in bits 15:0, zeros above |
| grant_start | input | 1 | One-cycle pulse at the start of a new bus tenure |
| peer_req | input | 1 | Another master is requesting the bus |
| release_req | output | 1 | Asks the current owner to give up the bus |

## Verification
Two events can land on the same edge: a register write and a grant-start reload. The bench drives `cfg_wr` with a new limit together with `grant_start`. It then counts the cycles until `release_req` rises under a held peer request, and that count must match the old limit. A following grant must then use the new limit. A second overlap, where a write arrives during a countdown already in progress, is judged the same way: the release timing must follow the limit that was loaded at the grant.

// File: rtl/hold_pkg.sv
package hold_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned LIMIT_W = 16;
  localparam int unsigned PAD_W   = WORD_W - LIMIT_W;
  localparam logic [LIMIT_W-1:0] LIMIT_RST = {LIMIT_W{1'b1}};

  typedef logic [LIMIT_W-1:0] limit_t;

  // one saturating step of the down-counter
  function automatic limit_t step_down(input limit_t cur);
    return (cur == '0) ? '0 : limit_t'(cur - 1'b1);
  endfunction

  function automatic logic at_floor(input limit_t cur);
    return cur == '0;
  endfunction

  function automatic limit_t take_field(input logic [WORD_W-1:0] w);
    return w[LIMIT_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] make_word(input limit_t v);
    return {{PAD_W{1'b0}}, v};
  endfunction
endpackage

// File: rtl/hold_cfg_reg.sv
module hold_cfg_reg
  import hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output limit_t            limit
);
  limit_t lim_q;

  always_ff @(posedge clk) begin
    if (rst)     lim_q <= LIMIT_RST;
    else if (wr) lim_q <= take_field(wdata);
  end

  assign limit = lim_q;
  assign rdata = make_word(lim_q);

  AST_LIMIT_KEEP: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(limit)); // R7
  AST_LIMIT_TAKE: assert property (@(posedge clk) disable iff (rst)
    wr |=> limit == $past(wdata[LIMIT_W-1:0])); // R2
endmodule

// File: rtl/hold_down_counter.sv
module hold_down_counter
  import hold_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  limit_t load_val,
  output limit_t count,
  output logic   active,
  output logic   expired
);
  limit_t cnt_q;
  logic   act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      act_q <= 1'b1;
    end else if (act_q) begin
      cnt_q <= step_down(cnt_q);
    end
  end

  assign count   = cnt_q;
  assign active  = act_q;
  assign expired = act_q && at_floor(cnt_q);

  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!load && active && count != '0) |=> count == $past(count) - 1'b1); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && active && count == '0) |=> count == '0); // R6
endmodule

// File: rtl/hold_release_gen.sv
module hold_release_gen (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic expired,
  input  logic peer_req,
  output logic release_req
);
  assign release_req = !rst && active && expired && peer_req;

  AST_NEED_PEER: assert property (@(posedge clk) disable iff (rst)
    release_req |-> peer_req); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !active |-> !release_req); // R10
endmodule

// File: rtl/bus_hold_limiter.sv
module bus_hold_limiter
  import hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              grant_start,
  input  logic              peer_req,
  output logic              release_req
);
  limit_t limit;
  limit_t count;
  logic   active;
  logic   expired;

  hold_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .limit(limit)
  );

  hold_down_counter u_cnt (
    .clk(clk), .rst(rst), .load(grant_start), .load_val(limit),
    .count(count), .active(active), .expired(expired)
  );

  hold_release_gen u_rel (
    .clk(clk), .rst(rst), .active(active), .expired(expired),
    .peer_req(peer_req), .release_req(release_req)
  );

  AST_AFTER_RESET: assert property (@(posedge clk)
    $fell(rst) |-> !release_req); // R1
  AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (grant_start && limit != '0) |=> !release_req); // R9
endmodule

// File: tb/sim_bus_hold_limiter.sv
module sim_bus_hold_limiter;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_wr = 0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        grant_start = 0;
  logic        peer_req = 0;
  logic        release_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        rel;
    logic [63:0] rd;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // bench-side view of the requirements
  logic [15:0] m_lim = 16'hFFFF;
  int          m_cnt = 0;
  bit          m_act = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_hold_limiter u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .grant_start(grant_start),
    .peer_req(peer_req), .release_req(release_req)
  );

  task automatic cyc(input bit r, input bit we, input logic [63:0] wd,
                     input bit gs, input bit pr, input string tag);
    exp_t e;
    rst = r; cfg_wr = we; cfg_wdata = wd; grant_start = gs; peer_req = pr;
    @(posedge clk);
    if (r) begin
      m_lim = 16'hFFFF; m_cnt = 0; m_act = 0;
    end else begin
      if (gs) begin m_cnt = m_lim; m_act = 1; end
      else if (m_act && m_cnt > 0) m_cnt = m_cnt - 1;
      if (we) m_lim = wd[15:0];
    end
    e.rel = (!r && m_act && m_cnt == 0 && pr);
    e.rd  = {48'h0, m_lim};
    e.tag = tag;
    #2 sb.push_back(e);
    #3;
  endtask

  // monitor: compares design outputs with queued expectations
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (release_req !== e.rel) begin
          errors++;
          $display("FAIL %s release_req actual=%0b expected=%0b", e.tag, release_req, e.rel);
        end
        checks++;
        if (cfg_rdata !== e.rd) begin
          errors++;
          $display("FAIL %s cfg_rdata actual=%h expected=%h", e.tag, cfg_rdata, e.rd);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P/2);
    // R1 reset state
    for (int i = 0; i < 3; i++) cyc(1, 0, '0, 0, 1, "R1");
    cyc(0, 0, '0, 0, 1, "R1");
    // R10 no release before any grant
    for (int i = 0; i < 4; i++) cyc(0, 0, '0, 0, 1, "R10");
    // R2 write with upper bits set
    cyc(0, 1, 64'hDEAD_BEEF_0000_0003, 0, 0, "R2");
    cyc(0, 0, '0, 0, 0, "R2");
    // R3/R4 countdown of 3 with peer pending
    cyc(0, 0, '0, 1, 1, "R3");
    for (int i = 0; i < 4; i++) cyc(0, 0, '0, 0, 1, "R4");
    // R6 hold at zero, follow peer
    for (int i = 0; i < 3; i++) cyc(0, 0, '0, 0, 1, "R6");
    cyc(0, 0, '0, 0, 0, "R6");
    cyc(0, 0, '0, 0, 1, "R6");
    // R9 new grant withdraws release
    cyc(0, 0, '0, 1, 1, "R9");
    cyc(0, 0, '0, 0, 1, "R9");
    // R5 uncontended long tenure
    cyc(0, 1, 64'h0000_0000_0000_0002, 0, 0, "R5");
    cyc(0, 0, '0, 1, 0, "R5");
    for (int i = 0; i < 12; i++) cyc(0, 0, '0, 0, 0, "R5");
    // R7 write during countdown leaves it alone
    cyc(0, 1, 64'h0000_0000_0000_0006, 0, 0, "R7");
    cyc(0, 0, '0, 1, 1, "R7");
    cyc(0, 0, '0, 0, 1, "R7");
    cyc(0, 1, 64'h0000_0000_0000_0001, 0, 1, "R7");
    for (int i = 0; i < 6; i++) cyc(0, 0, '0, 0, 1, "R7");
    // R7 write on the grant edge loads the old limit
    cyc(0, 1, 64'h0000_0000_0000_0004, 1, 1, "R7");
    for (int i = 0; i < 3; i++) cyc(0, 0, '0, 0, 1, "R7");
    cyc(0, 0, '0, 1, 1, "R7");
    for (int i = 0; i < 6; i++) cyc(0, 0, '0, 0, 1, "R7");
    // R8 limit of zero
    cyc(0, 1, '0, 0, 0, "R8");
    cyc(0, 0, '0, 1, 0, "R8");
    cyc(0, 0, '0, 0, 0, "R8");
    cyc(0, 0, '0, 0, 1, "R8");
    cyc(0, 0, '0, 1, 1, "R8");
    cyc(0, 0, '0, 0, 1, "R8");
    // R1 reset mid-tenure
    cyc(1, 0, '0, 0, 1, "R1");
    cyc(0, 0, '0, 0, 1, "R1");
    cyc(0, 0, '0, 0, 0, "R1");
    #(CLK_P);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule